// File: doc/BRIEF.md
# Serial-to-Parallel Word Deserializer with Bit Slip

This block turns a retimed serial bit stream into 16-bit parallel words, clocked by a word clock that it divides down from the serial clock. The serial clock comes from an external recovered-clock source and is an input. A select line picks the serial source: either the normal line input or a loopback input used for diagnostics.

Framing logic downstream cannot see the word boundary directly. It asks for a slip by raising a request line. Once that request has been high long enough to qualify, the block drops one serial bit from the stream. Each slip moves the word boundary by one bit position, so repeated requests walk the alignment until the frame pattern lines up. The parallel word changes on the falling edge of the word clock, which lets the consumer capture it on the rising edge.

Top module: `ser2par_slip`

## Requirements
- R1: Each parallel word holds the 16 most recent serial bits. The earliest of them is on `word_out[15]` and the latest is on `word_out[0]`.
- R2: With no slip, `word_clk` repeats every 16 serial clock cycles. In each period it is high for 8 samples and low for 8 samples.
- R3: `word_out` changes only on the serial clock edge where `word_clk` falls.
- R4: The serial bit is taken from `ser_main` when `loop_sel` is 0 and from `ser_loop` when `loop_sel` is 1. A change of `loop_sel` takes effect at the next serial clock edge, so one word may carry bits from both sources.
- R5: A slip request counts only when `slip_req` is sampled high on at least 4 consecutive serial clock edges. A shorter pulse has no effect on word timing.
- R6: A qualified request causes exactly one slip, however long `slip_req` stays high. A further slip needs `slip_req` to go low and then qualify again.
- R7: A slip holds the bit counter for one serial cycle. That word clock period lasts 17 cycles, and the word that ends it still carries only the last 16 bits, so the oldest bit is dropped.
- R8: Word timing does not drift through runs of more than 2000 identical serial bits.
- R9: While `rst_n` is low, `word_out` is zero and `word_clk` is low. Reset is applied asynchronously and released synchronously to `clk_ser`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ser | input | 1 | Serial bit clock from the recovered-clock source |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_main | input | 1 | Normal serial data input |
| ser_loop | input | 1 | Loopback serial data input |
| loop_sel | input | 1 | Source select: 0 takes `ser_main`, 1 takes `ser_loop` |
| slip_req | input | 1 | Bit-slip request; must stay high for 4 serial cycles to qualify |
| word_clk | output | 1 | Word clock, serial clock divided by 16 |
| word_out | output | 16 | Parallel word, updated on the falling edge of `word_clk` |

## Verification
The bench tracks its own history of the bits it drives, following `loop_sel` edge by edge. At every falling edge of `word_clk` it compares `word_out` against that history and measures the length of the period that just ended. Requests of 1 and 3 cycles test the qualification threshold, since a design that qualified too early would stretch a word it should not. A 40-cycle request must give exactly one 17-cycle period; a design that did not rearm only after the request went low would slip again and again. Two separate pulses must give two slips. A run of more than 2000 identical bits must keep every period at 16 cycles, and a counter that drifted or depended on data transitions would break that. Changing the source in the middle of a word catches a mux that is steered by the wrong select polarity or that switches late.

// File: rtl/s2p_pkg.sv
package s2p_pkg;
  localparam int unsigned S2P_WORD_W = 16;
  localparam int unsigned S2P_QUAL   = 4;
endpackage

// File: rtl/s2p_rst_sync.sv
module s2p_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_ok = s1_q;
endmodule

// File: rtl/s2p_slip_qual.sv
module s2p_slip_qual #(
  parameter int unsigned QUAL = s2p_pkg::S2P_QUAL
) (
  input  logic clk,
  input  logic rst_ok,
  input  logic slip_req,
  output logic hold
);
  localparam int unsigned RW = $clog2(QUAL + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(QUAL);
  localparam logic [RW-1:0] RUN_ARM = RW'(QUAL - 1);

  logic [RW-1:0] run_q, run_nxt;
  logic          fire_q, fire_nxt;

  always_comb begin
    run_nxt  = '0;
    fire_nxt = 1'b0;
    if (slip_req) begin
      run_nxt  = (run_q == RUN_MAX) ? RUN_MAX : run_q + 1'b1;
      fire_nxt = (run_q == RUN_ARM);
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      run_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      run_q  <= run_nxt;
      fire_q <= fire_nxt;
    end
  end

  assign hold = fire_q;

  // R6: a qualified request yields a single hold cycle
  a_r6_single_fire: assert property (@(posedge clk) disable iff (!rst_ok)
    fire_q |=> !fire_q);
  // R5: a hold is only ever preceded by a high request sample
  a_r5_fire_needs_req: assert property (@(posedge clk) disable iff (!rst_ok)
    fire_q |-> $past(slip_req));
endmodule

// File: rtl/s2p_word_timer.sv
module s2p_word_timer #(
  parameter int unsigned WORD_W = s2p_pkg::S2P_WORD_W
) (
  input  logic clk,
  input  logic rst_ok,
  input  logic hold,
  output logic wrap,
  output logic word_clk
);
  localparam int unsigned CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);
  localparam logic [CW-1:0] HALF = CW'(WORD_W / 2);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          wclk_q, wclk_nxt;

  always_comb begin
    wrap = 1'b0;
    if (hold) begin
      cnt_nxt = cnt_q;
    end else if (cnt_q == LAST) begin
      cnt_nxt = '0;
      wrap    = 1'b1;
    end else begin
      cnt_nxt = cnt_q + 1'b1;
    end
    wclk_nxt = (cnt_nxt >= HALF);
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      cnt_q  <= '0;
      wclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      wclk_q <= wclk_nxt;
    end
  end

  assign word_clk = wclk_q;

  // R2: the word clock falls only as the counter wraps to zero
  a_r2_fall_at_wrap: assert property (@(posedge clk) disable iff (!rst_ok)
    $fell(wclk_q) |-> (cnt_q == '0));
  // R7: a slip freezes the bit counter for one cycle
  a_r7_hold_freezes: assert property (@(posedge clk) disable iff (!rst_ok)
    hold |=> $stable(cnt_q));
endmodule

// File: rtl/s2p_shifter.sv
module s2p_shifter #(
  parameter int unsigned WORD_W = s2p_pkg::S2P_WORD_W
) (
  input  logic              clk,
  input  logic              rst_ok,
  input  logic              bit_in,
  input  logic              load,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] sr_q, sr_nxt;
  logic [WORD_W-1:0] out_q, out_nxt;

  always_comb begin
    sr_nxt  = {sr_q[WORD_W-2:0], bit_in};
    out_nxt = load ? sr_nxt : out_q;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      sr_q  <= '0;
      out_q <= '0;
    end else begin
      sr_q  <= sr_nxt;
      out_q <= out_nxt;
    end
  end

  assign word = out_q;
endmodule

// File: rtl/ser2par_slip.sv
module ser2par_slip #(
  parameter int unsigned WORD_W = s2p_pkg::S2P_WORD_W,
  parameter int unsigned QUAL   = s2p_pkg::S2P_QUAL
) (
  input  logic              clk_ser,
  input  logic              rst_n,
  input  logic              ser_main,
  input  logic              ser_loop,
  input  logic              loop_sel,
  input  logic              slip_req,
  output logic              word_clk,
  output logic [WORD_W-1:0] word_out
);
  logic rst_ok;
  logic ser_bit;
  logic hold;
  logic wrap;

  s2p_rst_sync u_rst (
    .clk    (clk_ser),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  assign ser_bit = loop_sel ? ser_loop : ser_main;

  s2p_slip_qual #(.QUAL(QUAL)) u_qual (
    .clk      (clk_ser),
    .rst_ok   (rst_ok),
    .slip_req (slip_req),
    .hold     (hold)
  );

  s2p_word_timer #(.WORD_W(WORD_W)) u_timer (
    .clk      (clk_ser),
    .rst_ok   (rst_ok),
    .hold     (hold),
    .wrap     (wrap),
    .word_clk (word_clk)
  );

  s2p_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk    (clk_ser),
    .rst_ok (rst_ok),
    .bit_in (ser_bit),
    .load   (wrap),
    .word   (word_out)
  );

  // R3: the parallel word moves only with a falling word clock
  a_r3_out_on_fall: assert property (@(posedge clk_ser) disable iff (!rst_ok)
    !$stable(word_out) |-> $fell(word_clk));
  // R1: a falling word clock always coincides with a fresh word load
  a_r1_fall_loads: assert property (@(posedge clk_ser) disable iff (!rst_ok)
    $fell(word_clk) |-> $past(wrap));
endmodule

// File: tb/tb_ser2par_slip.sv
module tb_ser2par_slip;
  logic        clk_ser = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_main = 1'b0, ser_loop = 1'b0, loop_sel = 1'b0, slip_req = 1'b0;
  logic        word_clk;
  logic [15:0] word_out;

  int n_run = 0, n_fail = 0;
  int stretches = 0;
  int per = 0, hi = 0;
  bit first = 1'b1, prev_wclk = 1'b0, done = 1'b0;
  logic [15:0] hist = '0;

  always #10 clk_ser = ~clk_ser;

  ser2par_slip dut (
    .clk_ser(clk_ser), .rst_n(rst_n), .ser_main(ser_main), .ser_loop(ser_loop),
    .loop_sel(loop_sel), .slip_req(slip_req), .word_clk(word_clk), .word_out(word_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench history of the bit it presented on each edge (R4 source choice)
  always @(posedge clk_ser) hist <= {hist[14:0], (loop_sel ? ser_loop : ser_main)};

  always @(negedge clk_ser) begin
    if (!rst_n) begin
      first = 1'b1; per = 0; hi = 0; prev_wclk = 1'b0;
    end else begin
      per++;
      if (word_clk) hi++;
      if (prev_wclk && !word_clk) begin
        chk(word_out == hist, "R1/R4/R7 word data", word_out, hist);
        if (!first) begin
          chk(per == 16 || per == 17, "R2/R8 period", per, 16);
          if (per == 17) stretches++;
          else chk(hi == 8, "R2 high time", hi, 8);
        end
        first = 1'b0; per = 0; hi = 0;
      end
      prev_wclk = word_clk;
    end
  end

  typedef struct packed {
    logic        sel;
    logic [15:0] m;
    logic [15:0] l;
    logic [7:0]  w;
    logic [1:0]  exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 16'hA5C3, 16'h0F0F, 8'd0,  2'd0},
    '{1'b1, 16'hFFFF, 16'h3C96, 8'd0,  2'd0},
    '{1'b0, 16'h1234, 16'h0000, 8'd3,  2'd0},
    '{1'b0, 16'h8001, 16'hFFFF, 8'd4,  2'd1},
    '{1'b1, 16'h0000, 16'h6B2D, 8'd40, 2'd1},
    '{1'b0, 16'hF00F, 16'h5555, 8'd1,  2'd0}
  };

  task automatic drive(input vec_t v, input int idx, input bit req);
    @(negedge clk_ser);
    loop_sel = v.sel;
    ser_main = v.m[15 - (idx % 16)];
    ser_loop = v.l[15 - (idx % 16)];
    slip_req = req;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    vec_t v;
    int base;
    repeat (3) @(negedge clk_ser);
    chk(word_out == 16'h0, "R9 reset word", word_out, 0);
    chk(word_clk == 1'b0, "R9 reset clock", word_clk, 0);
    @(negedge clk_ser) rst_n = 1'b1;

    for (int k = 0; k < 6; k++) begin
      v = VECS[k];
      base = stretches;
      for (int i = 0; i < 24; i++) drive(v, i, 1'b0);
      for (int i = 0; i < int'(v.w); i++) drive(v, 24 + i, 1'b1);
      for (int i = 0; i < 48; i++) drive(v, 24 + int'(v.w) + i, 1'b0);
      chk(stretches - base == int'(v.exp), "R5/R6 slip count", stretches - base, v.exp);
    end

    // R8: long run of identical bits, no slip
    base = stretches;
    for (int i = 0; i < 2100; i++) begin
      @(negedge clk_ser); loop_sel = 1'b0; ser_main = 1'b1; slip_req = 1'b0;
    end
    chk(stretches == base, "R8 no drift", stretches - base, 0);
    chk(word_out == 16'hFFFF, "R8 word after run", word_out, 16'hFFFF);

    // R6: two separate qualified pulses give two slips
    base = stretches;
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 5; i++) begin
        @(negedge clk_ser); slip_req = 1'b1; ser_main = i[0];
      end
      for (int i = 0; i < 40; i++) begin
        @(negedge clk_ser); slip_req = 1'b0; ser_main = i[1];
      end
    end
    chk(stretches - base == 2, "R6 two pulses", stretches - base, 2);

    // R9: reset in mid-stream clears outputs
    repeat (5) @(negedge clk_ser);
    rst_n = 1'b0;
    @(negedge clk_ser);
    chk(word_out == 16'h0, "R9 mid-run reset word", word_out, 0);
    chk(word_clk == 1'b0, "R9 mid-run reset clock", word_clk, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule